// File: doc/BRIEF.md
# Port Pad Configuration and Resolution

This block holds the pad settings for one eight-pin I/O port and turns them into the controls a pad ring needs. Software writes three per-pin registers over a small register bus: one asks for the internal pull resistor, one asks for limited edge rate, and one asks for strong drive. A fourth register holds a single bit that marks whether one designated pin still belongs to the background-debug function. These registers are separate from the port's data and direction registers, which live elsewhere.

For every pin, the stored requests are combined with live mode inputs: the general-purpose direction, whether a shared peripheral owns the pin and is driving it, whether an analog function holds it, and whether the keyboard-interrupt logic watches it for rising edges. The result is four pad controls per pin: pull on, pull polarity, edge-rate limiting and strong drive. The resolution is combinational, so a mode change reaches the pad in the same cycle.

Top module: `padctl_port`

## Requirements
- R1: A write (wr_en high at a rising edge) to address 0 loads the pull-request register, address 1 the slew-request register, address 2 the drive-request register, and bit 0 of address 3 the debug-ownership bit; `rdata` shows the register selected by `addr` (address 3 reads as seven zeros above the ownership bit).
- R2: A rising edge with `rst` high clears the pull and drive registers, sets every slew bit to 1 and sets the debug-ownership bit to 1.
- R3: A pin counts as driving when it is not analog and either the peripheral owns it and `per_oe` is 1, or the peripheral does not own it and `gpio_dir` is 1 (1 = output); a driving pin has `pull_en_o` at 0 whatever its pull bit.
- R4: A pin with `ana_en` high has `pull_en_o` at 0.
- R5: `pull_dn_o` (1 = pull to ground, 0 = pull to supply) is 1 only when the pull is on and both `kbi_en` and `kbi_rise` are 1 for that pin; otherwise 0.
- R6: `slew_o` equals the slew bit while the pin is driving and is 0 otherwise.
- R7: `hdrv_o` equals the drive bit while the pin is driving and is 0 otherwise.
- R8: `rdata` returns the stored register value, not the resolved pad control.
- R9: All pad outputs follow the registers and mode inputs combinationally, with no cycle of delay.
- R10: While the ownership bit is 1, pin 4 shows pull on, pulled to supply, no slew limiting and low drive, ignoring its registers and mode inputs; `dbg_own_o` shows the bit.
- R11: With `wr_en` low no register changes, whatever `addr` and `wdata` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| gpio_dir | input | 8 | Port direction, 1 = output |
| per_own | input | 8 | Shared peripheral owns the pin |
| per_oe | input | 8 | Peripheral drives the pin when it owns it |
| ana_en | input | 8 | Analog function holds the pin |
| kbi_en | input | 8 | Keyboard interrupt watches the pin |
| kbi_rise | input | 8 | Keyboard interrupt edge is rising |
| pull_en_o | output | 8 | Resolved pull device enable |
| pull_dn_o | output | 8 | Resolved pull polarity, 1 = to ground |
| slew_o | output | 8 | Resolved edge-rate limiting |
| hdrv_o | output | 8 | Resolved strong drive |
| dbg_own_o | output | 1 | Debug function still owns pin 4 |

## Verification
The assertions take for granted that every mode input is a known level at each rising edge and that `per_oe` matters only on pins whose `per_own` bit is set, so the ownership select is evaluated the same way by design and checker. The bench changes all inputs only just after a falling edge, so they are settled long before the next rising edge, and draws them from uniform random bits so every mix of ownership, direction, analog and keyboard settings appears, including pins where `per_oe` disagrees with `gpio_dir`.

// File: rtl/padctl_pkg.sv
`timescale 1ns/1ps
package padctl_pkg;

    typedef enum logic [1:0] {
        SEL_PULL  = 2'd0,
        SEL_SLEW  = 2'd1,
        SEL_DRIVE = 2'd2,
        SEL_DBG   = 2'd3
    } pad_sel_e;

    // stored software requests for one pin
    typedef struct packed {
        logic pull_req;
        logic slew_req;
        logic drive_req;
    } pin_cfg_t;

    // live usage of one pin
    typedef struct packed {
        logic driving;
        logic analog;
        logic rise_watch;
    } pin_mode_t;

    // resolved pad controls of one pin
    typedef struct packed {
        logic pull_on;
        logic pull_down;
        logic slew_on;
        logic high_drv;
    } pad_ctl_t;

    localparam pad_ctl_t DEBUG_CTL = '{pull_on: 1'b1, pull_down: 1'b0,
                                       slew_on: 1'b0, high_drv: 1'b0};

    function automatic logic pin_drives(logic dir, logic own, logic oe, logic ana);
        return !ana && (own ? oe : dir);
    endfunction

    function automatic pad_ctl_t resolve_pin(pin_cfg_t c, pin_mode_t m);
        pad_ctl_t r;
        r.pull_on   = c.pull_req && !m.driving && !m.analog;
        r.pull_down = r.pull_on && m.rise_watch;
        r.slew_on   = c.slew_req && m.driving;
        r.high_drv  = c.drive_req && m.driving;
        return r;
    endfunction

endpackage

// File: rtl/padctl_regs.sv
`timescale 1ns/1ps
module padctl_regs
    import padctl_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  pad_sel_e        sel,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] pull_q,
    output logic [PINS-1:0] slew_q,
    output logic [PINS-1:0] drive_q,
    output logic            dbg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pull_q  <= '0;
            slew_q  <= '1;
            drive_q <= '0;
            dbg_q   <= 1'b1;
        end else if (wr_en) begin
            unique case (sel)
                SEL_PULL:  pull_q  <= wdata;
                SEL_SLEW:  slew_q  <= wdata;
                SEL_DRIVE: drive_q <= wdata;
                SEL_DBG:   dbg_q   <= wdata[0];
                default: ;
            endcase
        end
    end

    logic seen_q;
    always_ff @(posedge clk) seen_q <= 1'b1;

    a_r1_pull_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_PULL) |=> (pull_q == $past(wdata)));
    a_r1_drive_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_DRIVE) |=> (drive_q == $past(wdata)));
    a_r2_reset_values: assert property (@(posedge clk)
        (seen_q && $past(rst)) |-> (pull_q == '0 && slew_q == '1 && drive_q == '0 && dbg_q));
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(pull_q) && $stable(slew_q) && $stable(drive_q) && $stable(dbg_q)));

endmodule

// File: rtl/padctl_mode.sv
`timescale 1ns/1ps
module padctl_mode
    import padctl_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            [PINS-1:0] gpio_dir,
    input  logic            [PINS-1:0] per_own,
    input  logic            [PINS-1:0] per_oe,
    input  logic            [PINS-1:0] ana_en,
    input  logic            [PINS-1:0] kbi_en,
    input  logic            [PINS-1:0] kbi_rise,
    output pin_mode_t       [PINS-1:0] mode
);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        always_comb begin
            mode[i].driving    = pin_drives(gpio_dir[i], per_own[i], per_oe[i], ana_en[i]);
            mode[i].analog     = ana_en[i];
            mode[i].rise_watch = kbi_en[i] && kbi_rise[i];
        end
    end

endmodule

// File: rtl/padctl_resolve.sv
`timescale 1ns/1ps
module padctl_resolve
    import padctl_pkg::*;
#(
    parameter int PINS    = 8,
    parameter int DBG_PIN = 4
) (
    input  pin_cfg_t  [PINS-1:0] cfg,
    input  pin_mode_t [PINS-1:0] mode,
    input  logic                 dbg_own,
    output pad_ctl_t  [PINS-1:0] ctl
);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        if (i == DBG_PIN) begin : g_dbg
            always_comb ctl[i] = dbg_own ? DEBUG_CTL : resolve_pin(cfg[i], mode[i]);
        end else begin : g_plain
            always_comb ctl[i] = resolve_pin(cfg[i], mode[i]);
        end
    end

endmodule

// File: rtl/padctl_port.sv
`timescale 1ns/1ps
module padctl_port
    import padctl_pkg::*;
#(
    parameter int PINS    = 8,
    parameter int DBG_PIN = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] rdata,
    input  logic [PINS-1:0] gpio_dir,
    input  logic [PINS-1:0] per_own,
    input  logic [PINS-1:0] per_oe,
    input  logic [PINS-1:0] ana_en,
    input  logic [PINS-1:0] kbi_en,
    input  logic [PINS-1:0] kbi_rise,
    output logic [PINS-1:0] pull_en_o,
    output logic [PINS-1:0] pull_dn_o,
    output logic [PINS-1:0] slew_o,
    output logic [PINS-1:0] hdrv_o,
    output logic            dbg_own_o
);

    pad_sel_e               sel;
    logic      [PINS-1:0]   pull_q, slew_q, drive_q;
    logic                   dbg_q;
    pin_cfg_t  [PINS-1:0]   cfg;
    pin_mode_t [PINS-1:0]   mode;
    pad_ctl_t  [PINS-1:0]   ctl;

    assign sel = pad_sel_e'(addr);

    padctl_regs #(.PINS(PINS)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(wdata),
        .pull_q(pull_q), .slew_q(slew_q), .drive_q(drive_q), .dbg_q(dbg_q)
    );

    padctl_mode #(.PINS(PINS)) u_mode (
        .gpio_dir(gpio_dir), .per_own(per_own), .per_oe(per_oe),
        .ana_en(ana_en), .kbi_en(kbi_en), .kbi_rise(kbi_rise), .mode(mode)
    );

    padctl_resolve #(.PINS(PINS), .DBG_PIN(DBG_PIN)) u_res (
        .cfg(cfg), .mode(mode), .dbg_own(dbg_q), .ctl(ctl)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        localparam bit IS_DBG = (i == DBG_PIN);
        always_comb begin
            cfg[i].pull_req  = pull_q[i];
            cfg[i].slew_req  = slew_q[i];
            cfg[i].drive_req = drive_q[i];
        end
        assign pull_en_o[i] = ctl[i].pull_on;
        assign pull_dn_o[i] = ctl[i].pull_down;
        assign slew_o[i]    = ctl[i].slew_on;
        assign hdrv_o[i]    = ctl[i].high_drv;

        a_r3_no_pull_driving: assert property (@(posedge clk) disable iff (rst)
            ((per_own[i] ? per_oe[i] : gpio_dir[i]) && !(IS_DBG && dbg_own_o)) |-> !pull_en_o[i]);
        a_r4_no_pull_analog: assert property (@(posedge clk) disable iff (rst)
            (ana_en[i] && !(IS_DBG && dbg_own_o)) |-> !pull_en_o[i]);
        a_r5_down_needs_rise: assert property (@(posedge clk) disable iff (rst)
            pull_dn_o[i] |-> (pull_en_o[i] && kbi_en[i] && kbi_rise[i]));
        a_r6_slew_needs_output: assert property (@(posedge clk) disable iff (rst)
            slew_o[i] |-> (!ana_en[i] && (per_own[i] ? per_oe[i] : gpio_dir[i]) && slew_q[i]));
        a_r7_drive_needs_output: assert property (@(posedge clk) disable iff (rst)
            hdrv_o[i] |-> (!ana_en[i] && (per_own[i] ? per_oe[i] : gpio_dir[i]) && drive_q[i]));
    end

    assign dbg_own_o = dbg_q;

    always_comb begin
        unique case (sel)
            SEL_PULL:  rdata = pull_q;
            SEL_SLEW:  rdata = slew_q;
            SEL_DRIVE: rdata = drive_q;
            default:   rdata = {{(PINS-1){1'b0}}, dbg_q};
        endcase
    end

    a_r10_debug_pin: assert property (@(posedge clk) disable iff (rst)
        dbg_own_o |-> (pull_en_o[DBG_PIN] && !pull_dn_o[DBG_PIN] && !slew_o[DBG_PIN] && !hdrv_o[DBG_PIN]));

endmodule

// File: tb/padctl_port_bench.sv
`timescale 1ns/1ps
module padctl_port_bench;

    localparam int DBG = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1, wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] gpio_dir = '0, per_own = '0, per_oe = '0, ana_en = '0, kbi_en = '0, kbi_rise = '0;
    logic [7:0] pull_en_o, pull_dn_o, slew_o, hdrv_o;
    logic       dbg_own_o;

    padctl_port u_padctl_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .gpio_dir(gpio_dir), .per_own(per_own), .per_oe(per_oe), .ana_en(ana_en),
        .kbi_en(kbi_en), .kbi_rise(kbi_rise), .pull_en_o(pull_en_o), .pull_dn_o(pull_dn_o),
        .slew_o(slew_o), .hdrv_o(hdrv_o), .dbg_own_o(dbg_own_o)
    );

    // reference state
    logic [7:0] m_pe = 8'h00, m_se = 8'hFF, m_ds = 8'h00;
    logic       m_dbg = 1'b1;
    logic       p_rst = 1'b1, p_wr = 1'b0;
    logic [1:0] p_addr = '0;
    logic [7:0] p_wdata = '0;
    int total = 0, bad = 0;
    string tag = "R2";

    task automatic check(string what, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic step(input logic r, input logic we, input logic [1:0] a, input logic [7:0] d,
                        input logic [7:0] dir, input logic [7:0] own, input logic [7:0] oe,
                        input logic [7:0] ana, input logic [7:0] ke, input logic [7:0] kr);
        logic [7:0] e_pe, e_pd, e_sl, e_hd, e_rd;
        @(negedge clk);
        // apply the edge that just passed to the model
        if (p_rst) begin
            m_pe = 8'h00; m_se = 8'hFF; m_ds = 8'h00; m_dbg = 1'b1;
        end else if (p_wr) begin
            if (p_addr == 2'd0) m_pe = p_wdata;
            else if (p_addr == 2'd1) m_se = p_wdata;
            else if (p_addr == 2'd2) m_ds = p_wdata;
            else m_dbg = p_wdata[0];
        end
        rst = r; wr_en = we; addr = a; wdata = d;
        gpio_dir = dir; per_own = own; per_oe = oe; ana_en = ana; kbi_en = ke; kbi_rise = kr;
        p_rst = r; p_wr = we; p_addr = a; p_wdata = d;
        #1;
        for (int i = 0; i < 8; i++) begin
            bit drv;
            drv = !ana[i] && (own[i] ? oe[i] : dir[i]);
            if (m_dbg && i == DBG) begin
                e_pe[i] = 1; e_pd[i] = 0; e_sl[i] = 0; e_hd[i] = 0;
            end else begin
                e_pe[i] = m_pe[i] && !drv && !ana[i];
                e_pd[i] = e_pe[i] && ke[i] && kr[i];
                e_sl[i] = m_se[i] && drv;
                e_hd[i] = m_ds[i] && drv;
            end
        end
        case (a)
            2'd0: e_rd = m_pe;
            2'd1: e_rd = m_se;
            2'd2: e_rd = m_ds;
            default: e_rd = {7'd0, m_dbg};
        endcase
        check("rdata", rdata, e_rd);
        check("pull_en", pull_en_o, e_pe);
        check("pull_dn", pull_dn_o, e_pd);
        check("slew", slew_o, e_sl);
        check("hdrv", hdrv_o, e_hd);
        check("dbg_own", {7'd0, dbg_own_o}, {7'd0, m_dbg});
    endtask

    function automatic logic [7:0] rnd();
        return 8'($urandom);
    endfunction

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R2: reset values, every address read while held
        tag = "R2";
        for (int k = 0; k < 4; k++) step(1, 0, 2'(k), 0, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) step(0, 0, 2'(k), 0, rnd(), 0, 0, 0, 0, 0);

        // R1: writes land in the addressed register
        tag = "R1";
        for (int k = 0; k < 24; k++) step(0, 1, 2'(k % 3), rnd(), rnd(), rnd(), rnd(), 0, 0, 0);
        step(0, 1, 2'd0, 8'hA5, 0, 0, 0, 0, 0, 0);
        step(0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0);

        // R10: debug pin keeps its fixed controls while owned
        tag = "R10";
        for (int k = 0; k < 12; k++) step(0, k[0], 2'(k % 3), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd());
        step(0, 1, 2'd3, 8'hFE, 0, 0, 0, 0, 0, 0);          // release
        step(0, 0, 2'd3, 0, 8'hFF, 0, 0, 0, 0, 0);

        // R8: reads show stored bits, not resolved ones
        tag = "R8";
        step(0, 1, 2'd0, 8'hFF, 8'hFF, 0, 0, 0, 0, 0);
        step(0, 0, 2'd0, 0, 8'hFF, 0, 0, 0, 0, 0);
        step(0, 1, 2'd2, 8'hFF, 8'h00, 0, 0, 0, 0, 0);
        step(0, 0, 2'd2, 0, 8'h00, 0, 0, 0, 0, 0);

        // R11: no write without strobe
        tag = "R11";
        for (int k = 0; k < 16; k++) step(0, 0, 2'(k), rnd(), rnd(), 0, 0, 0, 0, 0);

        // R3: direction and peripheral ownership silence the pull
        tag = "R3";
        step(0, 1, 2'd0, 8'hFF, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 20; k++) step(0, 0, 2'd0, 0, rnd(), rnd(), rnd(), 0, 0, 0);

        // R4: analog silences the pull
        tag = "R4";
        for (int k = 0; k < 12; k++) step(0, 0, 2'd0, 0, 0, 0, 0, rnd(), 0, 0);

        // R5: rising-edge keyboard watch flips polarity
        tag = "R5";
        for (int k = 0; k < 20; k++) step(0, 0, 2'd0, 0, rnd(), rnd(), rnd(), 0, rnd(), rnd());

        // R6: slew follows register only on driving pins
        tag = "R6";
        step(0, 1, 2'd1, 8'h3C, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 16; k++) step(0, 0, 2'd1, 0, rnd(), rnd(), rnd(), rnd(), 0, 0);

        // R7: strong drive only on driving pins
        tag = "R7";
        step(0, 1, 2'd2, 8'hC3, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 16; k++) step(0, 0, 2'd2, 0, rnd(), rnd(), rnd(), rnd(), 0, 0);

        // R9: everything mixed, outputs checked in the cycle inputs change
        tag = "R9";
        for (int k = 0; k < 200; k++)
            step(0, ($urandom % 3) == 0, 2'($urandom), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd());

        // R2: reset mid-run restores defaults, then R10 again
        tag = "R2";
        step(1, 0, 2'd1, 0, rnd(), rnd(), rnd(), rnd(), rnd(), rnd());
        for (int k = 0; k < 4; k++) step(0, 0, 2'(k), 0, rnd(), rnd(), rnd(), rnd(), rnd(), rnd());
        tag = "R10";
        step(0, 1, 2'd0, 8'h10, 8'h10, 0, 0, 0, 8'h10, 8'h10);
        step(0, 1, 2'd3, 8'h00, 8'h00, 0, 0, 0, 8'h10, 8'h10);
        step(0, 1, 2'd3, 8'h01, 8'h00, 0, 0, 0, 8'h10, 8'h10);
        step(0, 0, 2'd3, 0, 8'h00, 0, 0, 0, 8'h10, 8'h10);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule